// File: doc/BRIEF.md
# Frequency-Locking Oscillator Code Tuner

This block sets the control word of a digitally controlled oscillator so that the oscillator runs at a chosen frequency. The tuner is clocked by the oscillator it tunes. A slow, accurate reference clock of about 4 kHz provides the timing base. A free-running cycle counter in the fast domain is sampled on every rising reference edge. The difference between two successive samples gives the number of oscillator cycles in one reference period. That number is compared with a programmable target delta.

The 12-bit control word has two fields. A fine code of 8 bits sits in bits 7:0. A coarse range of 4 bits sits in bits 11:8. After each comparison the fine code takes one step. When the fine code wraps, the step carries into the range field or borrows from it, and the range field saturates at 0 and 15. Tuning stops on the first exact match, and the lock flag goes high. The word then holds its value until software issues a new start pulse.

Typical targets are 244, 1953, 2930 and 3906 oscillator cycles per reference period. These correspond to about 1, 8, 12 and 16 MHz against a 4096 Hz reference.

Top module: `freq_code_tuner`

## Requirements
- R1: While reset is low, and at the first clock after reset, the control word equals the INIT_WORD parameter and the lock flag is 0.
- R2: The reference clock passes through a two-flop synchronizer before edge detection. A rising reference edge can change the control word only on the single clock edge at which the synchronized edge is detected.
- R3: Each measurement is the modulo-2^16 difference between the free-running cycle counter and the previous sample. The previous sample is set to 0 by start, so the first measurement after a start is the raw counter value.
- R4: When the measurement exceeds the target, the fine code (bits 7:0) decrements. On a wrap from 0x00 to 0xFF, the range field (bits 11:8) decrements, but only if it is not already 0.
- R5: When the measurement is below the target, the fine code increments. On a wrap from 0xFF to 0x00, the range field increments, but only if it is not already 15.
- R6: When the measurement equals the target exactly, the lock flag goes high on the next clock and all adjustment stops. The control word then stays constant for as long as no start pulse arrives.
- R7: A start pulse clears the lock flag on the next clock, restarts the measurement and keeps the current control word as the starting point.
- R8: Before the first start pulse, reference edges are ignored, and the control word and lock flag keep their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast oscillator clock being tuned |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a tuning run |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| target_delta | input | 16 | Wanted oscillator cycles per reference period |
| ctrl_word | output | 12 | Control word: range in bits 11:8, fine code in bits 7:0 |
| locked | output | 1 | High once a measurement equalled the target |

## Verification
The testbench models the oscillator as a clock whose period shrinks steadily as the control word rises. Each tuning run is therefore a real closed loop.

A target that is too small forces a long series of decrements. This shows the borrow through 0x00 and the range field staying at 0. A second instance is given an unreachable target and starts near the top of the code space. This shows the carry through 0xFF and the range field staying at 15.

Two reachable targets are then tried. One is below the current frequency and one is above it, and the upward run crosses a fine-code carry. These runs tell apart stepping in the correct direction, stopping on an exact match, and holding the word after lock.

A phase with no start pulse shows that reference edges are ignored while idle. A second start after a lock shows that the flag clears and that the word is kept.

// File: rtl/tuner_pkg.sv
// Package shared by the oscillator code tuner.
// Holds the step decision type that passes from the decision logic to the code register.
package tuner_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/ref_edge_sync.sv
// Synchronizes an asynchronous slow clock into clk and flags each rising edge.
// Assumption: the input stays high and low for several clk periods each.
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] shreg;

    // Shift the async input through the synchronizer stages and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[LAST-1:0], async_in};
    end

    // A rising edge shows as the newest synced bit high while the history bit is low.
    always_comb rise = shreg[LAST-1] & ~shreg[LAST];
endmodule

// File: rtl/period_meter.sv
// Free-running cycle counter with a sample register.
// delta is the modulo-2^CNT_W count since the last sample. It is valid in the cycle in which capture is asserted.
// Assumption: clear and capture are never high together. The caller gives clear priority.
module period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    output logic [CNT_W-1:0] delta
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] prev_q;

    // Count every clock. The counter is never cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Zero the previous sample on clear, and take a new sample on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       prev_q <= '0;
        else if (clear)   prev_q <= '0;
        else if (capture) prev_q <= cnt_q;
    end

    // Measurement is the wrapped difference between the counter and the last sample.
    always_comb delta = cnt_q - prev_q;
endmodule

// File: rtl/code_stepper.sv
// Control word register: a coarse range field above a fine code.
// The fine code steps by one and wraps. The wrap carries into, or borrows from, a range field that saturates.
module code_stepper
    import tuner_pkg::*;
#(
    parameter int RANGE_W = 4,
    parameter int FINE_W  = 8,
    parameter logic [RANGE_W+FINE_W-1:0] INIT_WORD = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  step_e                     step,
    output logic [RANGE_W+FINE_W-1:0] word
);
    localparam logic [RANGE_W-1:0] RANGE_MAX = {RANGE_W{1'b1}};
    localparam logic [FINE_W-1:0]  FINE_MAX  = {FINE_W{1'b1}};

    logic [RANGE_W-1:0] range_q;
    logic [FINE_W-1:0]  fine_q;

    // Apply one step to the fine code, with a saturating carry or borrow into the range field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {range_q, fine_q} <= INIT_WORD;
        end else begin
            case (step)
                STEP_UP: begin
                    fine_q <= fine_q + 1'b1;
                    if (fine_q == FINE_MAX && range_q != RANGE_MAX) range_q <= range_q + 1'b1;
                end
                STEP_DOWN: begin
                    fine_q <= fine_q - 1'b1;
                    if (fine_q == '0 && range_q != '0) range_q <= range_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Present the fields as a single word, range on top.
    always_comb word = {range_q, fine_q};
endmodule

// File: rtl/freq_code_tuner.sv
// Top level of the oscillator code tuner. clk is the oscillator being tuned.
// On every synced reference rising edge during a run, it compares the measured cycle count with the target and steps the control word.
// It stops on the first exact match.
// Assumption: start is a single-cycle pulse that is synchronous to clk.
module freq_code_tuner
    import tuner_pkg::*;
#(
    parameter int RANGE_W = 4,
    parameter int FINE_W  = 8,
    parameter int CNT_W   = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [RANGE_W+FINE_W-1:0] INIT_WORD = 12'h005
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      ref_clk,
    input  logic [CNT_W-1:0]          target_delta,
    output logic [RANGE_W+FINE_W-1:0] ctrl_word,
    output logic                      locked
);
    logic             ref_rise;
    logic             active_q;
    logic             measure;
    logic [CNT_W-1:0] delta;
    step_e            step;

    ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ref_clk), .rise(ref_rise)
    );

    // A measurement is taken only on a reference edge during a run, and never in a start cycle.
    always_comb measure = active_q & ref_rise & ~start;

    period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst_n(rst_n), .clear(start), .capture(measure), .delta(delta)
    );

    // Pick the step direction from the comparison of the measurement with the target.
    always_comb begin
        step = STEP_HOLD;
        if (measure) begin
            if (delta > target_delta)      step = STEP_DOWN;
            else if (delta < target_delta) step = STEP_UP;
        end
    end

    code_stepper #(.RANGE_W(RANGE_W), .FINE_W(FINE_W), .INIT_WORD(INIT_WORD)) u_code (
        .clk(clk), .rst_n(rst_n), .step(step), .word(ctrl_word)
    );

    // Run and lock state: start opens a run, and an exact match closes it with lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            locked   <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            locked   <= 1'b0;
        end else if (measure && delta == target_delta) begin
            active_q <= 1'b0;
            locked   <= 1'b1;
        end
    end
endmodule

// File: rtl/freq_code_tuner_checker.sv
// Property checker for freq_code_tuner. It observes the ports and the synced edge strobe.
module freq_code_tuner_checker #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ref_rise,
    input logic [WORD_W-1:0] ctrl_word,
    input logic              locked
);
    // R2: the word moves only on the clock that follows a detected edge.
    p_edge_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_rise |=> $stable(ctrl_word));

    // R4: once the range field is 0, it can only stay at 0 or rise by one.
    p_range_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[WORD_W-1 -: 4] == 4'd0) |=> (ctrl_word[WORD_W-1 -: 4] <= 4'd1));

    // R5: once the range field is 15, it can only stay at 15 or fall by one.
    p_range_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[WORD_W-1 -: 4] == 4'd15) |=> (ctrl_word[WORD_W-1 -: 4] >= 4'd14));

    // R6: while locked and no start pulse arrives, the word is frozen.
    p_hold_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start) |=> $stable(ctrl_word));

    // R6: lock rises only right after a detected reference edge.
    p_lock_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_rise));

    // R7: a start pulse clears lock on the next clock.
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !locked);
endmodule

bind freq_code_tuner freq_code_tuner_checker #(.WORD_W(RANGE_W+FINE_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_rise(ref_rise),
    .ctrl_word(ctrl_word), .locked(locked)
);

// File: tb/test_freq_code_tuner.sv
`timescale 1ps/1ps

// Behavioural reference: integers for the synchronizer history, the counter, the sample and the word.
module tuner_ref_model #(
    parameter int INIT = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ref_clk,
    input  logic [15:0] target,
    output logic [11:0] exp_word,
    output logic        exp_locked
);
    int s1, s2, s3, cnt, prev, rng, fine, run, lk, d;

    always @(posedge clk) begin
        if (!rst_n) begin
            s1 = 0; s2 = 0; s3 = 0; cnt = 0; prev = 0;
            rng = INIT / 256; fine = INIT % 256; run = 0; lk = 0;
        end else begin
            if (start) begin
                run = 1; lk = 0; prev = 0;
            end else if (run == 1 && s2 == 1 && s3 == 0) begin
                d = (cnt - prev) & 16'hFFFF;
                prev = cnt;
                if (d == int'(target)) begin
                    run = 0; lk = 1;
                end else if (d > int'(target)) begin
                    if (fine == 0) begin fine = 255; if (rng > 0) rng = rng - 1; end
                    else fine = fine - 1;
                end else begin
                    if (fine == 255) begin fine = 0; if (rng < 15) rng = rng + 1; end
                    else fine = fine + 1;
                end
            end
            cnt = (cnt + 1) & 16'hFFFF;
            s3 = s2; s2 = s1; s1 = int'(ref_clk);
        end
        exp_word   = 12'(rng * 256 + fine);
        exp_locked = (lk != 0);
    end
endmodule

module test_freq_code_tuner;
    localparam int CLK_PERIOD_PS = 62500;     // oscillator period at control word 0
    localparam int OSC_K         = 16000000;  // period = OSC_K / (word + 256) ps
    localparam int REF_HALF_PS   = 1000000;   // 2 us reference period
    localparam int WATCHDOG      = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic        start_m = 1'b0, start_h = 1'b0;
    logic [15:0] tgt_m = 16'd1, tgt_h = 16'hFFFF;
    logic [11:0] word_m, word_h, exp_m, exp_h;
    logic        lock_m, lock_h, elock_m, elock_h;
    int          n_tests = 0, n_fail = 0, cyc = 0;
    logic        cmp_en = 1'b0;
    logic [11:0] held;

    freq_code_tuner i_freq_code_tuner (
        .clk(clk), .rst_n(rst_n), .start(start_m), .ref_clk(ref_clk),
        .target_delta(tgt_m), .ctrl_word(word_m), .locked(lock_m)
    );
    freq_code_tuner #(.INIT_WORD(12'hFE0)) i_freq_code_tuner_hi (
        .clk(clk), .rst_n(rst_n), .start(start_h), .ref_clk(ref_clk),
        .target_delta(tgt_h), .ctrl_word(word_h), .locked(lock_h)
    );
    tuner_ref_model #(.INIT(12'h005)) u_model_m (
        .clk(clk), .rst_n(rst_n), .start(start_m), .ref_clk(ref_clk),
        .target(tgt_m), .exp_word(exp_m), .exp_locked(elock_m)
    );
    tuner_ref_model #(.INIT(12'hFE0)) u_model_h (
        .clk(clk), .rst_n(rst_n), .start(start_h), .ref_clk(ref_clk),
        .target(tgt_h), .exp_word(exp_h), .exp_locked(elock_h)
    );

    // Oscillator model: the period shrinks monotonically as the main control word rises.
    initial begin
        forever begin
            int half;
            half = (OSC_K / (int'(word_m) + 256)) / 2;
            if ($isunknown(word_m)) half = CLK_PERIOD_PS / 2;
            #(half) clk = ~clk;
        end
    end

    // Reference clock, retimed to a falling oscillator edge so that it never races a sampling edge.
    initial begin
        forever begin
            #(REF_HALF_PS);
            @(negedge clk);
            ref_clk = ~ref_clk;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare both instances with their reference models on every clock.
    always @(negedge clk) begin
        cyc++;
        if (cmp_en) begin
            check("R2 R3 R4 R5 word main", int'(word_m), int'(exp_m));
            check("R6 R7 lock main", int'(lock_m), int'(elock_m));
            check("R4 R5 word hi", int'(word_h), int'(exp_h));
            check("R6 lock hi", int'(lock_h), int'(elock_h));
        end
        if (cyc > WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_ref_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge ref_clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse(input bit m, input bit h);
        @(negedge clk);
        start_m = m; start_h = h;
        @(negedge clk);
        start_m = 1'b0; start_h = 1'b0;
    endtask

    task automatic wait_lock();
        while (!lock_m) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check("R1 reset word", int'(word_m), 12'h005);
        check("R1 reset lock", int'(lock_m), 0);
        check("R1 reset word hi", int'(word_h), 12'hFE0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after release", int'(word_m), 12'h005);
        cmp_en = 1'b1;

        // R8: reference edges before any start are ignored
        wait_ref_edges(3);
        check("R8 idle word", int'(word_m), 12'h005);
        check("R8 idle lock", int'(lock_m), 0);

        // R4: unreachable low target: borrow out of fine 0x00 while the range field stays at 0
        pulse(1'b1, 1'b1);
        wait_ref_edges(12);
        check("R4 range floor", int'(word_m[11:8]), 0);
        check("R4 fine wrapped high", int'(word_m[7:0] >= 8'hE0), 1);

        // R6: reachable target below the current frequency
        tgt_m = 16'd40;
        pulse(1'b1, 1'b0);
        wait_lock();
        check("R6 lock reached down", int'(lock_m), 1);
        held = word_m;
        wait_ref_edges(4);
        check("R6 word held after lock", int'(word_m), int'(held));
        check("R6 lock held", int'(lock_m), 1);

        // R7: a new start clears lock and keeps the word. R5: the upward run carries into the range field.
        tgt_m = 16'd66;
        @(negedge clk);
        start_m = 1'b1;
        @(negedge clk);
        start_m = 1'b0;
        check("R7 lock cleared", int'(lock_m), 0);
        check("R7 word kept", int'(word_m), int'(held));
        wait_lock();
        check("R6 lock reached up", int'(lock_m), 1);
        check("R5 carry into range", int'(word_m[11:8]), 1);

        // R5: unreachable high target on the second instance saturates the range field at 15
        check("R5 range ceiling", int'(word_h[11:8]), 15);
        check("R5 no lock on unreachable", int'(lock_h), 0);

        cmp_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule